// File: doc/BRIEF.md
# Per-Target Frame Sequence Tracker

This block sits behind a host port that talks to up to sixteen targets through a port multiplier. It keeps one protocol context per target. Each context holds the kind of the command in flight, the step the command has reached and the bytes still to move. Every received frame is checked against the frame types that the target's context allows next. On a match the block tells a data engine what to do: accept a control frame, take in a data frame, or send out a data frame of a given size. It also reports the end of each command. A frame that breaks the sequence raises an error strobe and drops that target's context back to idle.

Frames for different targets may arrive in any interleaving, including between the data frames of one transfer. Each target's context is therefore saved and restored independently. A command-start event opens a context on an idle target. For queued commands the event also records the byte count for the command's tag in a per-tag table. A later DMA-setup frame selects that tag and loads the count from the table.

Frame type codes: 34h register response, 39h DMA activate, 41h DMA setup, 46h data, A1h set-device-bits. Command kind encoding on `cmd_kind`: 0 queued read, 1 queued write, 2 non-queued read, 3 non-queued write. Byte counts given at command start are nonzero.

Top module: `fst_tracker`

## Requirements
- R1: After reset every context is idle and no strobe is active. Any frame aimed at an idle target gives `act_error`.
- R2: Every frame (`frm_valid` high) produces exactly one of `act_accept` or `act_error` in the following cycle. `act_tgt` carries that frame's target.
- R3: For a non-queued read (kind 2), each data frame (46h) whose length is nonzero and no larger than the remaining count gives `act_accept` and `act_rx_data`, with `act_len` equal to the frame length. Once the count reaches zero, a register response (34h) gives `act_accept` and `act_done`.
- R4: For a non-queued write (kind 3), each DMA-activate frame (39h) gives `act_accept` and `act_tx_data`, with `act_len` equal to the smaller of the remaining count and 8192. Once the count reaches zero, a register response (34h) gives `act_done`.
- R5: For a queued command (kind 0 or 1), the first frame expected is a register response (34h) with `frm_intr` low. A DMA-setup frame (41h) follows. It loads the remaining count from the table entry for `frm_tag`, which the command start wrote from `cmd_tag` and `cmd_bytes`.
- R6: After the DMA-setup frame, a queued read continues as the data phase of R3 and a queued write continues as the activate/transmit phase of R4.
- R7: A queued command whose count has reached zero completes on a set-device-bits frame (A1h) with `act_accept` and `act_done`.
- R8: Frames for different targets may interleave freely. Each target's step and remaining count are unaffected by another target's frames and starts.
- R9: A frame type that is not allowed in the target's current step gives `act_error` alone, with `act_tgt` set. That target's context becomes idle.
- R10: A data frame with length zero, above 8192, or above the remaining count is a sequence error as in R9.
- R11: A command start for a target whose context is not idle is ignored. So is a start for the same target as a frame in the same cycle.
- R12: A register response with `frm_intr` high while a queued command awaits its first response is a sequence error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | A received frame is presented this cycle |
| frm_type | input | 8 | Frame type code |
| frm_tgt | input | 4 | Target number the frame came from |
| frm_len | input | 14 | Payload length of a data frame, bytes |
| frm_intr | input | 1 | Interrupt bit of a register-response frame |
| frm_tag | input | 5 | Tag selected by a DMA-setup frame |
| cmd_start | input | 1 | Command-start event |
| cmd_tgt | input | 4 | Target of the new command |
| cmd_kind | input | 2 | Command kind (0..3, see above) |
| cmd_tag | input | 5 | Tag of a queued command |
| cmd_bytes | input | 24 | Byte count of the command |
| act_accept | output | 1 | Frame accepted as legal |
| act_rx_data | output | 1 | Data engine: receive the data frame |
| act_tx_data | output | 1 | Data engine: transmit one data frame |
| act_done | output | 1 | Command complete on that target |
| act_error | output | 1 | Sequence error on that target |
| act_tgt | output | 4 | Target of the current strobe |
| act_len | output | 14 | Bytes to receive or transmit |

## Verification
The bench interleaves a long non-queued read on one target with a complete queued write on another. A design that shared state between targets would misroute or reject the second half of the read. It splits writes above 8192 bytes into a full chunk and a remainder, which catches a wrong chunk clamp or a count that never reaches zero. It drives each kind of illegal frame: a data frame that is too long, empty or oversize, a register response with the interrupt bit set, a set-device-bits frame where a register response is due, and any frame to an idle target. A design that forgot to return the context to idle would then accept the follow-up frame. It also sends a start to a busy target, and a start together with a frame on one target. A design that let the start through would expect the wrong frame next.

// File: rtl/fst_pkg.sv
package fst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_NCQ_REG   = 3'd1,
    ST_NCQ_SETUP = 3'd2,
    ST_RD_DATA   = 3'd3,
    ST_WR_ACT    = 3'd4,
    ST_FIN_REG   = 3'd5,
    ST_FIN_SDB   = 3'd6
  } ctx_state_t;

  typedef enum logic [1:0] {
    K_NCQ_RD = 2'd0,
    K_NCQ_WR = 2'd1,
    K_NQ_RD  = 2'd2,
    K_NQ_WR  = 2'd3
  } cmd_kind_t;

  typedef struct packed {
    ctx_state_t state;
    cmd_kind_t  kind;
  } ctx_t;

  localparam logic [7:0] FT_REG   = 8'h34;
  localparam logic [7:0] FT_ACT   = 8'h39;
  localparam logic [7:0] FT_SETUP = 8'h41;
  localparam logic [7:0] FT_DATA  = 8'h46;
  localparam logic [7:0] FT_SDB   = 8'hA1;

  localparam ctx_t CTX_IDLE = '{state: ST_IDLE, kind: K_NCQ_RD};

endpackage

// File: rtl/fst_ctx_store.sv
module fst_ctx_store
  import fst_pkg::*;
#(
  parameter int NUM_TGT = 16,
  parameter int CNT_W   = 24,
  localparam int IDX_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output ctx_t             ra_ctx,
  output logic [CNT_W-1:0] ra_cnt,
  input  logic [IDX_W-1:0] rb_idx,
  output ctx_t             rb_ctx,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  ctx_t             wa_ctx,
  input  logic [CNT_W-1:0] wa_cnt,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  ctx_t             wb_ctx,
  input  logic [CNT_W-1:0] wb_cnt
);

  ctx_t             ctx_q [NUM_TGT];
  logic [CNT_W-1:0] cnt_q [NUM_TGT];
  ctx_t             ctx_d [NUM_TGT];
  logic [CNT_W-1:0] cnt_d [NUM_TGT];
  logic             en    [NUM_TGT];

  // Port A (frame update) wins over port B (start); the top never aims both
  // at one target in the same cycle.
  always_comb begin
    for (int i = 0; i < NUM_TGT; i++) begin
      ctx_d[i] = ctx_q[i];
      cnt_d[i] = cnt_q[i];
      en[i]    = 1'b0;
      if (wa_en && (wa_idx == IDX_W'(i))) begin
        ctx_d[i] = wa_ctx;
        cnt_d[i] = wa_cnt;
        en[i]    = 1'b1;
      end else if (wb_en && (wb_idx == IDX_W'(i))) begin
        ctx_d[i] = wb_ctx;
        cnt_d[i] = wb_cnt;
        en[i]    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TGT; i++) begin
        ctx_q[i] <= CTX_IDLE;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_TGT; i++) begin
        if (en[i]) begin
          ctx_q[i] <= ctx_d[i];
          cnt_q[i] <= cnt_d[i];
        end
      end
    end
  end

  assign ra_ctx = ctx_q[ra_idx];
  assign ra_cnt = cnt_q[ra_idx];
  assign rb_ctx = ctx_q[rb_idx];

endmodule

// File: rtl/fst_tag_table.sv
module fst_tag_table #(
  parameter int NUM_TAG = 32,
  parameter int CNT_W   = 24,
  localparam int TAG_W  = (NUM_TAG > 1) ? $clog2(NUM_TAG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [CNT_W-1:0] rd_cnt
);

  logic [CNT_W-1:0] cnt_q [NUM_TAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TAG; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_TAG; i++) begin
        if (wr_en && (wr_tag == TAG_W'(i))) cnt_q[i] <= wr_cnt;
      end
    end
  end

  assign rd_cnt = cnt_q[rd_tag];

endmodule

// File: rtl/fst_seq_engine.sv
module fst_seq_engine
  import fst_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int LEN_W    = 14,
  parameter int MAX_XFER = 8192
) (
  input  ctx_t             cur_ctx,
  input  logic [CNT_W-1:0] cur_cnt,
  input  logic [7:0]       ftype,
  input  logic [LEN_W-1:0] flen,
  input  logic             fintr,
  input  logic [CNT_W-1:0] tag_cnt,
  output ctx_t             nxt_ctx,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic             o_acc,
  output logic             o_rxd,
  output logic             o_txd,
  output logic             o_done,
  output logic             o_err,
  output logic [LEN_W-1:0] o_len
);

  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_XFER);

  logic [CNT_W-1:0] flen_w;
  logic [CNT_W-1:0] chunk;
  logic [CNT_W-1:0] rem_rd;
  logic [CNT_W-1:0] rem_wr;
  logic             nonq;
  ctx_state_t       fin_st;
  logic             ok;

  always_comb begin
    flen_w = CNT_W'(flen);
    chunk  = (cur_cnt > MAX_C) ? MAX_C : cur_cnt;
    rem_rd = cur_cnt - flen_w;
    rem_wr = cur_cnt - chunk;
    nonq   = (cur_ctx.kind == K_NQ_RD) || (cur_ctx.kind == K_NQ_WR);
    fin_st = nonq ? ST_FIN_REG : ST_FIN_SDB;
  end

  always_comb begin
    nxt_ctx = cur_ctx;
    nxt_cnt = cur_cnt;
    ok      = 1'b0;
    o_rxd   = 1'b0;
    o_txd   = 1'b0;
    o_done  = 1'b0;
    o_len   = '0;
    unique case (cur_ctx.state)
      ST_NCQ_REG: begin
        if ((ftype == FT_REG) && !fintr) begin
          ok            = 1'b1;
          nxt_ctx.state = ST_NCQ_SETUP;
        end
      end
      ST_NCQ_SETUP: begin
        if (ftype == FT_SETUP) begin
          ok            = 1'b1;
          nxt_cnt       = tag_cnt;
          nxt_ctx.state = (cur_ctx.kind == K_NCQ_WR) ? ST_WR_ACT : ST_RD_DATA;
        end
      end
      ST_RD_DATA: begin
        if ((ftype == FT_DATA) && (flen_w != '0) && (flen_w <= MAX_C) &&
            (flen_w <= cur_cnt)) begin
          ok            = 1'b1;
          o_rxd         = 1'b1;
          o_len         = flen;
          nxt_cnt       = rem_rd;
          nxt_ctx.state = (rem_rd == '0) ? fin_st : ST_RD_DATA;
        end
      end
      ST_WR_ACT: begin
        if (ftype == FT_ACT) begin
          ok            = 1'b1;
          o_txd         = 1'b1;
          o_len         = LEN_W'(chunk);
          nxt_cnt       = rem_wr;
          nxt_ctx.state = (rem_wr == '0) ? fin_st : ST_WR_ACT;
        end
      end
      ST_FIN_REG: begin
        if (ftype == FT_REG) begin
          ok            = 1'b1;
          o_done        = 1'b1;
          nxt_ctx.state = ST_IDLE;
        end
      end
      ST_FIN_SDB: begin
        if (ftype == FT_SDB) begin
          ok            = 1'b1;
          o_done        = 1'b1;
          nxt_ctx.state = ST_IDLE;
        end
      end
      default: ok = 1'b0;
    endcase
    if (!ok) begin
      nxt_ctx = CTX_IDLE;
      nxt_cnt = '0;
    end
    o_acc = ok;
    o_err = !ok;
  end

endmodule

// File: rtl/fst_tracker.sv
module fst_tracker
  import fst_pkg::*;
#(
  parameter int NUM_TGT  = 16,
  parameter int NUM_TAG  = 32,
  parameter int CNT_W    = 24,
  parameter int MAX_XFER = 8192,
  localparam int TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1,
  localparam int TAG_W   = (NUM_TAG > 1) ? $clog2(NUM_TAG) : 1,
  localparam int LEN_W   = $clog2(MAX_XFER + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic [7:0]       frm_type,
  input  logic [TGT_W-1:0] frm_tgt,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             frm_intr,
  input  logic [TAG_W-1:0] frm_tag,
  input  logic             cmd_start,
  input  logic [TGT_W-1:0] cmd_tgt,
  input  logic [1:0]       cmd_kind,
  input  logic [TAG_W-1:0] cmd_tag,
  input  logic [CNT_W-1:0] cmd_bytes,
  output logic             act_accept,
  output logic             act_rx_data,
  output logic             act_tx_data,
  output logic             act_done,
  output logic             act_error,
  output logic [TGT_W-1:0] act_tgt,
  output logic [LEN_W-1:0] act_len
);

  ctx_t             cur_ctx;
  logic [CNT_W-1:0] cur_cnt;
  ctx_t             st_cur_ctx;
  ctx_t             nxt_ctx;
  logic [CNT_W-1:0] nxt_cnt;
  logic [CNT_W-1:0] tag_cnt;
  logic             e_acc, e_rxd, e_txd, e_done, e_err;
  logic [LEN_W-1:0] e_len;

  cmd_kind_t        st_kind;
  logic             st_nonq;
  logic             start_ok;
  ctx_t             st_ctx;
  logic [CNT_W-1:0] st_cnt;

  fst_ctx_store #(
    .NUM_TGT (NUM_TGT),
    .CNT_W   (CNT_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_idx (frm_tgt),
    .ra_ctx (cur_ctx),
    .ra_cnt (cur_cnt),
    .rb_idx (cmd_tgt),
    .rb_ctx (st_cur_ctx),
    .wa_en  (frm_valid),
    .wa_idx (frm_tgt),
    .wa_ctx (nxt_ctx),
    .wa_cnt (nxt_cnt),
    .wb_en  (start_ok),
    .wb_idx (cmd_tgt),
    .wb_ctx (st_ctx),
    .wb_cnt (st_cnt)
  );

  fst_tag_table #(
    .NUM_TAG (NUM_TAG),
    .CNT_W   (CNT_W)
  ) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (start_ok && !st_nonq),
    .wr_tag (cmd_tag),
    .wr_cnt (cmd_bytes),
    .rd_tag (frm_tag),
    .rd_cnt (tag_cnt)
  );

  fst_seq_engine #(
    .CNT_W    (CNT_W),
    .LEN_W    (LEN_W),
    .MAX_XFER (MAX_XFER)
  ) u_engine (
    .cur_ctx (cur_ctx),
    .cur_cnt (cur_cnt),
    .ftype   (frm_type),
    .flen    (frm_len),
    .fintr   (frm_intr),
    .tag_cnt (tag_cnt),
    .nxt_ctx (nxt_ctx),
    .nxt_cnt (nxt_cnt),
    .o_acc   (e_acc),
    .o_rxd   (e_rxd),
    .o_txd   (e_txd),
    .o_done  (e_done),
    .o_err   (e_err),
    .o_len   (e_len)
  );

  // Command start: accepted only on an idle target not hit by a frame now.
  always_comb begin
    st_kind  = cmd_kind_t'(cmd_kind);
    st_nonq  = (st_kind == K_NQ_RD) || (st_kind == K_NQ_WR);
    start_ok = cmd_start && (st_cur_ctx.state == ST_IDLE) &&
               !(frm_valid && (frm_tgt == cmd_tgt));
    st_ctx.kind = st_kind;
    if (!st_nonq)               st_ctx.state = ST_NCQ_REG;
    else if (st_kind == K_NQ_WR) st_ctx.state = ST_WR_ACT;
    else                        st_ctx.state = ST_RD_DATA;
    st_cnt = st_nonq ? cmd_bytes : '0;
  end

  logic             acc_d, rxd_d, txd_d, done_d, err_d;

  always_comb begin
    acc_d  = frm_valid && e_acc;
    rxd_d  = frm_valid && e_rxd;
    txd_d  = frm_valid && e_txd;
    done_d = frm_valid && e_done;
    err_d  = frm_valid && e_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_accept  <= 1'b0;
      act_rx_data <= 1'b0;
      act_tx_data <= 1'b0;
      act_done    <= 1'b0;
      act_error   <= 1'b0;
      act_tgt     <= '0;
      act_len     <= '0;
    end else begin
      act_accept  <= acc_d;
      act_rx_data <= rxd_d;
      act_tx_data <= txd_d;
      act_done    <= done_d;
      act_error   <= err_d;
      if (frm_valid) begin
        act_tgt <= frm_tgt;
        act_len <= e_len;
      end
    end
  end

endmodule

// File: rtl/fst_tracker_chk.sv
module fst_tracker_chk #(
  parameter int NUM_TGT  = 16,
  parameter int NUM_TAG  = 32,
  parameter int CNT_W    = 24,
  parameter int MAX_XFER = 8192,
  localparam int TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1,
  localparam int TAG_W   = (NUM_TAG > 1) ? $clog2(NUM_TAG) : 1,
  localparam int LEN_W   = $clog2(MAX_XFER + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic [7:0]       frm_type,
  input logic [TGT_W-1:0] frm_tgt,
  input logic [LEN_W-1:0] frm_len,
  input logic             act_accept,
  input logic             act_rx_data,
  input logic             act_tx_data,
  input logic             act_done,
  input logic             act_error,
  input logic [TGT_W-1:0] act_tgt,
  input logic [LEN_W-1:0] act_len
);

  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_XFER);

  // R2: a frame always yields a verdict next cycle, naming its target
  a_r2_frame_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> ((act_accept ^ act_error) && (act_tgt == $past(frm_tgt))));

  // R2: no verdict without a frame
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !(act_accept || act_error));

  // R9: an error strobe stands alone
  a_r9_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
    act_error |-> !(act_accept || act_rx_data || act_tx_data || act_done));

  // R3: receive action only for data frames, with the frame's length
  a_r3_rx_len: assert property (@(posedge clk) disable iff (!rst_n)
    act_rx_data |-> (act_accept && ($past(frm_type) == 8'h46) &&
                     (act_len == $past(frm_len))));

  // R10: a received length is never zero or above the frame limit
  a_r10_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_rx_data |-> ((act_len != '0) && (act_len <= MAX_L)));

  // R4: transmit action only for DMA activate, with a legal chunk size
  a_r4_tx_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    act_tx_data |-> (act_accept && ($past(frm_type) == 8'h39) &&
                     (act_len != '0) && (act_len <= MAX_L)));

  // R7: completion only on register-response or set-device-bits frames
  a_r7_done_type: assert property (@(posedge clk) disable iff (!rst_n)
    act_done |-> (act_accept && (($past(frm_type) == 8'h34) ||
                                 ($past(frm_type) == 8'hA1))));

  // R2: at most one action kind per cycle
  a_r2_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_rx_data, act_tx_data, act_done}));

endmodule

bind fst_tracker fst_tracker_chk #(
  .NUM_TGT  (NUM_TGT),
  .NUM_TAG  (NUM_TAG),
  .CNT_W    (CNT_W),
  .MAX_XFER (MAX_XFER)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frm_valid   (frm_valid),
  .frm_type    (frm_type),
  .frm_tgt     (frm_tgt),
  .frm_len     (frm_len),
  .act_accept  (act_accept),
  .act_rx_data (act_rx_data),
  .act_tx_data (act_tx_data),
  .act_done    (act_done),
  .act_error   (act_error),
  .act_tgt     (act_tgt),
  .act_len     (act_len)
);

// File: tb/tb_fst_tracker.sv
`timescale 1ns/1ps
module tb_fst_tracker;

  localparam int NT = 16;
  localparam int NG = 32;
  localparam int MX = 8192;

  logic        clk;
  logic        rst_n;
  logic        frm_valid;
  logic [7:0]  frm_type;
  logic [3:0]  frm_tgt;
  logic [13:0] frm_len;
  logic        frm_intr;
  logic [4:0]  frm_tag;
  logic        cmd_start;
  logic [3:0]  cmd_tgt;
  logic [1:0]  cmd_kind;
  logic [4:0]  cmd_tag;
  logic [23:0] cmd_bytes;
  logic        act_accept, act_rx_data, act_tx_data, act_done, act_error;
  logic [3:0]  act_tgt;
  logic [13:0] act_len;

  fst_tracker dut (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_type(frm_type), .frm_tgt(frm_tgt),
    .frm_len(frm_len), .frm_intr(frm_intr), .frm_tag(frm_tag),
    .cmd_start(cmd_start), .cmd_tgt(cmd_tgt), .cmd_kind(cmd_kind),
    .cmd_tag(cmd_tag), .cmd_bytes(cmd_bytes),
    .act_accept(act_accept), .act_rx_data(act_rx_data),
    .act_tx_data(act_tx_data), .act_done(act_done), .act_error(act_error),
    .act_tgt(act_tgt), .act_len(act_len)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string req = "R1";

  // Behavioural reference: step names per target, remaining bytes, tag table
  // 0 idle, 1 await first reg, 2 await setup, 3 reading, 4 writing,
  // 5 await final reg, 6 await sdb
  int m_st   [NT];
  int m_kind [NT];
  int m_cnt  [NT];
  int m_tab  [NG];

  bit e_acc, e_rxd, e_txd, e_done, e_err;
  int e_tgt, e_len;

  task automatic model(input bit fv, input int ft, input int fg, input int fl,
                       input bit fi, input int fa, input bit sv, input int sk,
                       input int sg, input int sa, input int sb);
    int st, cnt, k, ns, nc, fin;
    bit ok;
    e_acc = 0; e_rxd = 0; e_txd = 0; e_done = 0; e_err = 0;
    e_tgt = fg; e_len = 0;
    if (fv) begin
      st = m_st[fg]; cnt = m_cnt[fg]; k = m_kind[fg];
      ok = 0; ns = st; nc = cnt;
      fin = (k >= 2) ? 5 : 6;
      if (st == 1 && ft == 'h34 && !fi) begin ok = 1; ns = 2; end
      else if (st == 2 && ft == 'h41) begin
        ok = 1; nc = m_tab[fa]; ns = (k == 1) ? 4 : 3;
      end else if (st == 3 && ft == 'h46 && fl > 0 && fl <= MX && fl <= cnt) begin
        ok = 1; e_rxd = 1; e_len = fl; nc = cnt - fl; ns = (nc == 0) ? fin : 3;
      end else if (st == 4 && ft == 'h39) begin
        ok = 1; e_txd = 1; e_len = (cnt > MX) ? MX : cnt;
        nc = cnt - e_len; ns = (nc == 0) ? fin : 4;
      end else if ((st == 5 && ft == 'h34) || (st == 6 && ft == 'hA1)) begin
        ok = 1; e_done = 1; ns = 0;
      end
      if (ok) e_acc = 1;
      else begin e_err = 1; ns = 0; nc = 0; end
      m_st[fg] = ns; m_cnt[fg] = nc;
    end
    if (sv && m_st[sg] == 0 && !(fv && fg == sg)) begin
      m_kind[sg] = sk;
      m_st[sg]   = (sk == 3) ? 4 : (sk == 2) ? 3 : 1;
      m_cnt[sg]  = (sk >= 2) ? sb : 0;
      if (sk < 2) m_tab[sa] = sb;
    end
  endtask

  task automatic compare();
    bit bad;
    checks++;
    bad = {act_accept, act_rx_data, act_tx_data, act_done, act_error} !=
          {e_acc, e_rxd, e_txd, e_done, e_err};
    if ((e_acc || e_err) && act_tgt != 4'(e_tgt)) bad = 1;
    if ((e_rxd || e_txd) && act_len != 14'(e_len)) bad = 1;
    if (bad) begin
      errors++;
      $display("FAIL %s: acc/rx/tx/done/err=%b%b%b%b%b tgt=%0d len=%0d expected %b%b%b%b%b tgt=%0d len=%0d",
               req, act_accept, act_rx_data, act_tx_data, act_done, act_error,
               act_tgt, act_len, e_acc, e_rxd, e_txd, e_done, e_err, e_tgt, e_len);
    end
  endtask

  // One cycle: drive at a falling edge, compare at the next falling edge
  task automatic step(input bit fv, input int ft, input int fg, input int fl,
                      input bit fi, input int fa, input bit sv, input int sk,
                      input int sg, input int sa, input int sb);
    frm_valid = fv; frm_type = 8'(ft); frm_tgt = 4'(fg); frm_len = 14'(fl);
    frm_intr = fi; frm_tag = 5'(fa);
    cmd_start = sv; cmd_kind = 2'(sk); cmd_tgt = 4'(sg); cmd_tag = 5'(sa);
    cmd_bytes = 24'(sb);
    model(fv, ft, fg, fl, fi, fa, sv, sk, sg, sa, sb);
    @(negedge clk);
    compare();
  endtask

  task automatic frm(input int g, input int t, input int l, input bit i, input int a);
    step(1, t, g, l, i, a, 0, 0, 0, 0, 0);
  endtask

  task automatic start(input int g, input int k, input int b, input int a);
    step(0, 0, 0, 0, 0, 0, 1, k, g, a, b);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NT; i++) begin m_st[i] = 0; m_kind[i] = 0; m_cnt[i] = 0; end
    for (int i = 0; i < NG; i++) m_tab[i] = 0;
    frm_valid = 0; frm_type = 0; frm_tgt = 0; frm_len = 0; frm_intr = 0;
    frm_tag = 0; cmd_start = 0; cmd_tgt = 0; cmd_kind = 0; cmd_tag = 0;
    cmd_bytes = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    req = "R1";            // reset state, frame to an idle target
    idle(); idle();
    frm(2, 'h46, 100, 0, 0);
    frm(0, 'h34, 0, 0, 0);

    req = "R8";            // read on 7 interleaved with queued write on 3
    start(7, 2, 10000, 0);
    start(3, 1, 9000, 8);
    frm(7, 'h46, 8192, 0, 0);
    req = "R5";
    frm(3, 'h34, 0, 0, 0);
    frm(3, 'h41, 0, 0, 8);
    req = "R3";
    frm(7, 'h46, 1808, 0, 0);
    req = "R6";
    frm(3, 'h39, 0, 0, 0);
    req = "R3";
    frm(7, 'h34, 0, 0, 0);
    req = "R6";
    frm(3, 'h39, 0, 0, 0);
    req = "R7";
    frm(3, 'hA1, 0, 0, 0);
    idle();

    req = "R4";            // non-queued write below one chunk
    start(5, 3, 100, 0);
    frm(5, 'h39, 0, 0, 0);
    frm(5, 'h34, 0, 1, 0);

    req = "R12";           // interrupt bit set on first queued response
    start(1, 0, 4096, 0);
    frm(1, 'h34, 0, 1, 0);
    frm(1, 'h34, 0, 0, 0);
    req = "R5";
    start(1, 0, 4096, 0);
    frm(1, 'h34, 0, 0, 0);
    frm(1, 'h41, 0, 0, 0);
    req = "R6";
    frm(1, 'h46, 4096, 0, 0);
    req = "R7";
    frm(1, 'hA1, 0, 0, 0);

    req = "R10";           // over-long, empty and oversize data frames
    start(4, 2, 1000, 0);
    frm(4, 'h46, 1001, 0, 0);
    frm(4, 'h46, 10, 0, 0);
    start(4, 2, 1000, 0);
    frm(4, 'h46, 0, 0, 0);
    start(4, 2, 20000, 0);
    frm(4, 'h46, 8193, 0, 0);

    req = "R11";           // start to busy target, start clashing with frame
    start(6, 2, 500, 0);
    start(6, 3, 50, 0);
    frm(6, 'h46, 500, 0, 0);
    frm(6, 'h34, 0, 0, 0);
    step(1, 'h34, 9, 0, 0, 0, 1, 2, 9, 0, 64);
    frm(9, 'h46, 64, 0, 0);

    req = "R9";            // wrong type mid-transfer, then target idle
    start(10, 3, 300, 0);
    frm(10, 'h46, 300, 0, 0);
    frm(10, 'h39, 0, 0, 0);
    start(11, 2, 40, 0);
    frm(11, 'h46, 40, 0, 0);
    frm(11, 'hA1, 0, 0, 0);
    frm(11, 'h34, 0, 0, 0);

    req = "R8";            // two queued reads, shared table, crossed order
    start(12, 0, 300, 3);
    start(13, 0, 700, 4);
    frm(13, 'h34, 0, 0, 0);
    frm(12, 'h34, 0, 0, 0);
    frm(12, 'h41, 0, 0, 4);
    frm(13, 'h41, 0, 0, 3);
    frm(13, 'h46, 300, 0, 0);
    frm(12, 'h46, 699, 0, 0);
    frm(13, 'hA1, 0, 0, 0);
    frm(12, 'h46, 1, 0, 0);
    frm(12, 'hA1, 0, 0, 0);

    req = "R2";
    idle(); idle();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule